// File: doc/BRIEF.md
# Comparator Timer Channel

This block is one channel of an event timer. It does not count by itself. It watches a shared free-running main counter that another block supplies, and it raises an expiry event when that counter reaches a programmable comparator value. The channel can run as a one-shot or as a periodic source. In periodic mode it keeps a hidden period value and advances the comparator by that amount after each expiry.

A narrow mode restricts the comparator, the period and all comparisons to the low half of the counter width. In narrow one-shot mode the channel also signals when the counter's low half wraps, if that wrap comes before the programmed match. Bus decode, the counter itself and interrupt routing are separate blocks. The channel receives already-decoded write strobes for its configuration and for each half of its comparator, and it returns an expiry pulse and an interrupt line.

The configuration word has five bits: bit 0 enables the channel, bit 1 selects periodic mode, bit 2 selects narrow mode, bit 3 is the set-value request and bit 4 selects level-type interrupts.

Top module: `event_cmp_channel`

## Requirements
- R1: After reset the comparator reads all ones, the configuration reads zero, the hidden period is zero, the wrap flag is clear, and both `fire_o` and `irq_o` are low.
- R2: An armed one-shot channel in wide mode produces exactly one `fire_o` pulse. The pulse appears one clock after the first edge at which the signed 64-bit difference (counter minus comparator) is zero or positive. After that pulse the channel is disarmed.
- R3: In periodic mode each expiry adds the period to the comparator, so pulses follow at comparator, comparator+period, and so on.
- R4: If the counter is already past the advanced comparator, the channel keeps adding the period, one addition per clock, until the comparator is ahead of the counter. These catch-up additions produce no extra pulses.
- R5: A write to a comparator half loads the comparator in one-shot mode. In periodic mode it loads only the period, unless the set-value bit (bit 3) is set; in that case a low-half write loads both the comparator and the period.
- R6: The set-value bit clears itself after a write to either comparator half.
- R7: A value stored as the period has its top bit forced to zero: bit 31 in narrow mode, bit 63 in wide mode.
- R8: In narrow mode (bit 2) the upper halves of the comparator and the period are zero, writes to the upper comparator half have no effect, and expiry tests use the signed difference modulo 2^32.
- R9: In narrow one-shot mode, if the counter's low half wraps past 0xFFFFFFFF before the match, the wrap gives one pulse and the real match gives a second pulse later.
- R10: A 0-to-1 change of the enable bit arms the channel when the global enable is high. A 1-to-0 change disarms it and drops `irq_o`. While the global enable is low the channel is disarmed. A rising global enable arms an enabled channel whose comparator is not all ones.
- R11: A comparator write while the channel and the global enable are both on re-arms the channel with the new value, even after a one-shot expiry.
- R12: In edge mode `irq_o` follows `fire_o`. In level mode (bit 4) an expiry sets `irq_o` and holds it until `irq_ack` is pulsed or the channel is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glb_en | input | 1 | Global enable shared by all channels |
| main_cnt | input | 64 | Shared main counter value |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration write data |
| cmp_lo_we | input | 1 | Write strobe for the comparator low half |
| cmp_hi_we | input | 1 | Write strobe for the comparator high half |
| wr_data | input | 32 | Data for comparator half writes |
| irq_ack | input | 1 | Clears a held level interrupt |
| cfg_q | output | 5 | Current configuration |
| cmp_q | output | 64 | Current comparator value |
| fire_o | output | 1 | Single-cycle expiry pulse |
| irq_o | output | 1 | Interrupt line, edge or level type |

## Verification
The expiry function is driven with a counter that steps by one, which shows exact match timing and pulse counts for one-shot and periodic settings. It is also driven with a counter that jumps far past the comparator, which separates catch-up additions from real expiries. A narrow-mode run places the counter's upper half away from zero, which shows that only the low half is compared and that a masked period bit is really dropped. A run that starts just below the low-half wrap tells the extra wrap pulse apart from the later match. Global-enable gating, re-arming on a write and the level interrupt with acknowledge are each tested in their own sequence.

// File: rtl/ecc_pkg.sv
`timescale 1ns/1ps
// ecc_pkg: shared types for the comparator timer channel.
// Assumes a five-bit configuration word in the bit order of the struct below.
package ecc_pkg;
    localparam int CFG_W = 5;

    // Configuration word, bit 4 down to bit 0.
    typedef struct packed {
        logic level;     // bit 4: level-type interrupt
        logic setval;    // bit 3: set-value request, self-clearing
        logic narrow;    // bit 2: half-width compare
        logic periodic;  // bit 1: periodic mode
        logic enable;    // bit 0: channel enable
    } ecc_cfg_t;
endpackage

// File: rtl/ecc_regs.sv
`timescale 1ns/1ps
// ecc_regs: configuration, comparator and hidden period registers.
// Applies half writes with mode-dependent routing, masks the period's top bit,
// keeps narrow-mode upper halves at zero, and adds the period on request.
// Assumes that writes and the advance request do not target the comparator in the same cycle.
module ecc_regs
    import ecc_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  ecc_cfg_t              cfg_wr,
    input  logic                  cmp_lo_we,
    input  logic                  cmp_hi_we,
    input  logic [CNT_W/2-1:0]    wr_data,
    input  logic                  adv,
    output ecc_cfg_t              cfg_r,
    output logic [CNT_W-1:0]      cmp_r,
    output logic [CNT_W-1:0]      per_r,
    output logic [CNT_W-1:0]      cmp_n,
    output logic                  narrow_n,
    output logic                  periodic_n
);
    localparam int HALF_W = CNT_W / 2;

    ecc_cfg_t          cfg_n;
    logic [CNT_W-1:0]  per_n;
    logic              route_cmp;

    assign route_cmp  = !cfg_r.periodic || cfg_r.setval;
    assign narrow_n   = cfg_n.narrow;
    assign periodic_n = cfg_n.periodic;

    // Next-state logic for all three registers.
    always_comb begin
        cfg_n = cfg_r;
        cmp_n = cmp_r;
        per_n = per_r;
        if (cfg_we) cfg_n = cfg_wr;
        if (cmp_lo_we) begin
            if (route_cmp) cmp_n[HALF_W-1:0] = wr_data;
            if (cfg_r.periodic) per_n[HALF_W-1:0] = wr_data;
        end
        if (cmp_hi_we) begin
            if (route_cmp) cmp_n[CNT_W-1:HALF_W] = wr_data;
            else per_n[CNT_W-1:HALF_W] = wr_data;
        end
        if (cmp_lo_we || cmp_hi_we) begin
            cfg_n.setval = 1'b0;
        end else if (adv) begin
            if (cfg_r.narrow)
                cmp_n = {{HALF_W{1'b0}}, cmp_r[HALF_W-1:0] + per_r[HALF_W-1:0]};
            else
                cmp_n = cmp_r + per_r;
        end
        if (cfg_n.narrow) begin
            cmp_n[CNT_W-1:HALF_W]   = '0;
            per_n[CNT_W-1:HALF_W-1] = '0;
        end else begin
            per_n[CNT_W-1] = 1'b0;
        end
    end

    // State registers with the reset values of an idle channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_r <= '0;
            cmp_r <= '1;
            per_r <= '0;
        end else begin
            cfg_r <= cfg_n;
            cmp_r <= cmp_n;
            per_r <= per_n;
        end
    end
endmodule

// File: rtl/ecc_match.sv
`timescale 1ns/1ps
// ecc_match: combinational compare logic.
// Produces the due condition (signed difference at full or half width),
// detects a low-half wrap against the previous counter sample, and decides
// at arm time whether a narrow one-shot must expect a wrap before its match.
module ecc_match #(
    parameter int CNT_W = 64
) (
    input  logic [CNT_W-1:0]    cnt,
    input  logic [CNT_W/2-1:0]  cnt_prev_lo,
    input  logic [CNT_W-1:0]    cmp,
    input  logic                narrow,
    input  logic [CNT_W-1:0]    cmp_n,
    input  logic                narrow_n,
    input  logic                periodic_n,
    output logic                due,
    output logic                wrapped,
    output logic                wrap_need
);
    localparam int HALF_W = CNT_W / 2;

    logic [CNT_W-1:0]  diff_w;
    logic [HALF_W-1:0] diff_h;
    logic [HALF_W-1:0] ahead;
    logic [HALF_W-1:0] ahead_eff;
    logic [HALF_W-1:0] room;

    // Expiry test: counter at or past comparator, modulo the active width.
    always_comb begin
        diff_w = cnt - cmp;
        diff_h = cnt[HALF_W-1:0] - cmp[HALF_W-1:0];
        due    = narrow ? !diff_h[HALF_W-1] : !diff_w[CNT_W-1];
    end

    // Low-half wrap: the current sample is below the previous one.
    assign wrapped = cnt[HALF_W-1:0] < cnt_prev_lo;

    // Arm-time wrap decision against the incoming comparator value.
    always_comb begin
        ahead     = cmp_n[HALF_W-1:0] - cnt[HALF_W-1:0];
        ahead_eff = (ahead[HALF_W-1] || ahead == '0) ? HALF_W'(1) : ahead;
        room      = ~cnt[HALF_W-1:0];
        wrap_need = narrow_n && !periodic_n && (room < ahead_eff);
    end
endmodule

// File: rtl/event_cmp_channel.sv
`timescale 1ns/1ps
// event_cmp_channel: one comparator channel of an event timer.
// Watches an external main counter, arms and disarms on enable edges and
// comparator writes, fires one registered pulse per match or wrap event, and
// runs periodic catch-up one addition per clock without extra pulses.
// Assumes the main counter is owned elsewhere and writes arrive pre-decoded.
module event_cmp_channel
    import ecc_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  glb_en,
    input  logic [CNT_W-1:0]      main_cnt,
    input  logic                  cfg_we,
    input  logic [CFG_W-1:0]      cfg_wdata,
    input  logic                  cmp_lo_we,
    input  logic                  cmp_hi_we,
    input  logic [CNT_W/2-1:0]    wr_data,
    input  logic                  irq_ack,
    output logic [CFG_W-1:0]      cfg_q,
    output logic [CNT_W-1:0]      cmp_q,
    output logic                  fire_o,
    output logic                  irq_o
);
    localparam int HALF_W = CNT_W / 2;

    ecc_cfg_t          cfg_wr;
    ecc_cfg_t          cfg_r;
    logic [CNT_W-1:0]  cmp_r, per_r, cmp_n;
    logic              narrow_n, periodic_n;
    logic              due, wrapped, wrap_need;
    logic              adv, fire_set;
    logic              armed_q, armed_d, wrap_q, wrap_d, catch_q, catch_d;
    logic              glb_q, fire_q, status_q;
    logic [HALF_W-1:0] prev_lo;
    logic              en_rise, en_fall, glb_rise, cmp_wr, arm_now, disarm;

    assign cfg_wr = ecc_cfg_t'(cfg_wdata);

    ecc_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wr     (cfg_wr),
        .cmp_lo_we  (cmp_lo_we),
        .cmp_hi_we  (cmp_hi_we),
        .wr_data    (wr_data),
        .adv        (adv),
        .cfg_r      (cfg_r),
        .cmp_r      (cmp_r),
        .per_r      (per_r),
        .cmp_n      (cmp_n),
        .narrow_n   (narrow_n),
        .periodic_n (periodic_n)
    );

    ecc_match #(.CNT_W(CNT_W)) u_match (
        .cnt         (main_cnt),
        .cnt_prev_lo (prev_lo),
        .cmp         (cmp_r),
        .narrow      (cfg_r.narrow),
        .cmp_n       (cmp_n),
        .narrow_n    (narrow_n),
        .periodic_n  (periodic_n),
        .due         (due),
        .wrapped     (wrapped),
        .wrap_need   (wrap_need)
    );

    // Arm and disarm events from enable edges and comparator writes.
    always_comb begin
        en_rise  = cfg_we && cfg_wr.enable && !cfg_r.enable;
        en_fall  = cfg_we && !cfg_wr.enable && cfg_r.enable;
        glb_rise = glb_en && !glb_q;
        cmp_wr   = cmp_lo_we || cmp_hi_we;
        disarm   = !glb_en || en_fall;
        arm_now  = glb_en && (en_rise
                   || (glb_rise && cfg_r.enable && cmp_r != '1)
                   || (cmp_wr && cfg_r.enable && !en_fall));
    end

    // Channel sequencing: arm, wrap wait, expiry and periodic catch-up.
    always_comb begin
        adv      = 1'b0;
        fire_set = 1'b0;
        armed_d  = armed_q;
        wrap_d   = wrap_q;
        catch_d  = catch_q;
        if (disarm) begin
            armed_d = 1'b0;
            wrap_d  = 1'b0;
            catch_d = 1'b0;
        end else if (arm_now) begin
            armed_d = 1'b1;
            wrap_d  = wrap_need;
            catch_d = 1'b0;
        end else if (armed_q) begin
            if (wrap_q) begin
                if (wrapped) begin
                    fire_set = 1'b1;
                    wrap_d   = 1'b0;
                end
            end else if (catch_q) begin
                if (due) adv = 1'b1;
                else catch_d = 1'b0;
            end else if (due) begin
                fire_set = 1'b1;
                if (cfg_r.periodic && per_r != '0) begin
                    adv     = 1'b1;
                    catch_d = 1'b1;
                end else begin
                    armed_d = 1'b0;
                end
            end
        end
    end

    // Sequencing state, pulse register, level status and counter history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q  <= 1'b0;
            wrap_q   <= 1'b0;
            catch_q  <= 1'b0;
            glb_q    <= 1'b0;
            fire_q   <= 1'b0;
            status_q <= 1'b0;
            prev_lo  <= '0;
        end else begin
            armed_q <= armed_d;
            wrap_q  <= wrap_d;
            catch_q <= catch_d;
            glb_q   <= glb_en;
            fire_q  <= fire_set;
            prev_lo <= main_cnt[HALF_W-1:0];
            if (disarm)                       status_q <= 1'b0;
            else if (fire_set && cfg_r.level) status_q <= 1'b1;
            else if (irq_ack)                 status_q <= 1'b0;
        end
    end

    assign cfg_q  = cfg_r;
    assign cmp_q  = cmp_r;
    assign fire_o = fire_q;
    assign irq_o  = cfg_r.level ? status_q : fire_q;
endmodule

// File: rtl/ecc_checker.sv
`timescale 1ns/1ps
// ecc_checker: temporal properties of the channel's ports, bound to the top.
// Assumes configuration bit order: enable 0, periodic 1, narrow 2, setval 3, level 4.
module ecc_checker #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             glb_en,
    input logic             cfg_we,
    input logic [4:0]       cfg_wdata,
    input logic             cmp_lo_we,
    input logic             cmp_hi_we,
    input logic [4:0]       cfg_q,
    input logic [CNT_W-1:0] cmp_q,
    input logic             fire_o,
    input logic             irq_o
);
    // R10: dropping the enable bit silences both outputs on the next cycle.
    a_r10_disarm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_wdata[0] && cfg_q[0]) |=> (!irq_o && !fire_o));

    // R10: no pulse follows a cycle with the global enable low.
    a_r10_global_off: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> !fire_o);

    // R6: set-value is gone after a comparator half write.
    a_r6_setval_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmp_lo_we || cmp_hi_we) && !cfg_we) |=> !cfg_q[3]);

    // R8: narrow mode keeps the comparator's upper half at zero.
    a_r8_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[2] |-> (cmp_q[CNT_W-1:CNT_W/2] == '0));

    // R2, R4: outside narrow mode a pulse is never followed by another at once.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && !cfg_q[2]) |=> !fire_o);
endmodule

bind event_cmp_channel ecc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .glb_en    (glb_en),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cmp_lo_we (cmp_lo_we),
    .cmp_hi_we (cmp_hi_we),
    .cfg_q     (cfg_q),
    .cmp_q     (cmp_q),
    .fire_o    (fire_o),
    .irq_o     (irq_o)
);

// File: tb/event_cmp_channel_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module event_cmp_channel_bench;
    localparam logic [4:0] EN = 5'h01, PER = 5'h02, NAR = 5'h04, SETV = 5'h08, LVL = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        glb_en = 1'b0;
    logic [63:0] main_cnt = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_wdata = '0;
    logic        cmp_lo_we = 1'b0;
    logic        cmp_hi_we = 1'b0;
    logic [31:0] wr_data = '0;
    logic        irq_ack = 1'b0;
    logic [4:0]  cfg_q;
    logic [63:0] cmp_q;
    logic        fire_o;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    int nf = 0;
    int nirq = 0;
    logic [63:0] flog [64];

    always #5 clk = ~clk;

    event_cmp_channel u_event_cmp_channel (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .main_cnt(main_cnt),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cmp_lo_we(cmp_lo_we),
        .cmp_hi_we(cmp_hi_we), .wr_data(wr_data), .irq_ack(irq_ack),
        .cfg_q(cfg_q), .cmp_q(cmp_q), .fire_o(fire_o), .irq_o(irq_o)
    );

    // Pulse log: the counter value present at the edge that produced each pulse.
    always @(negedge clk) begin
        if (fire_o) begin
            flog[nf % 64] = main_cnt;
            nf = nf + 1;
        end
        if (irq_o) nirq = nirq + 1;
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr_cfg(input logic [4:0] v);
        tick(); cfg_we = 1'b1; cfg_wdata = v;
        tick(); cfg_we = 1'b0;
    endtask

    task automatic wr_lo(input logic [31:0] v);
        tick(); cmp_lo_we = 1'b1; wr_data = v;
        tick(); cmp_lo_we = 1'b0;
    endtask

    task automatic wr_hi(input logic [31:0] v);
        tick(); cmp_hi_we = 1'b1; wr_data = v;
        tick(); cmp_hi_we = 1'b0;
    endtask

    task automatic set_cnt(input logic [63:0] v);
        tick(); main_cnt = v;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            tick(); main_cnt = main_cnt + 64'd1;
        end
    endtask

    task automatic t_reset();
        tick();
        chk("R1 cmp", cmp_q, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R1 cfg", {59'd0, cfg_q}, 64'd0);
        chk("R1 fire", {63'd0, fire_o}, 64'd0);
        chk("R1 irq", {63'd0, irq_o}, 64'd0);
    endtask

    task automatic t_oneshot();
        int b, bi;
        tick(); glb_en = 1'b1;
        set_cnt(64'd100);
        wr_lo(32'd120);
        wr_hi(32'd0);
        chk("R5 oneshot load", cmp_q, 64'd120);
        b = nf; bi = nirq;
        wr_cfg(EN);
        run(40);
        chk("R2 count", 64'(nf - b), 64'd1);
        chk("R2 at", flog[b % 64], 64'd120);
        chk("R12 edge irq", 64'(nirq - bi), 64'd1);
    endtask

    task automatic t_periodic();
        int b;
        wr_cfg(5'h00);
        set_cnt(64'd1000);
        wr_cfg(PER | SETV);
        wr_lo(32'd1010);
        wr_hi(32'd0);
        wr_lo(32'd7);
        chk("R5 period-only write", cmp_q, 64'd1010);
        chk("R6 setval cleared", {59'd0, cfg_q}, {59'd0, PER});
        b = nf;
        wr_cfg(EN | PER);
        run(30);
        chk("R3 count", 64'(nf - b), 64'd3);
        chk("R3 second", flog[(b + 1) % 64], 64'd1017);
        chk("R3 third", flog[(b + 2) % 64], 64'd1024);
        chk("R3 cmp", cmp_q, 64'd1031);
    endtask

    task automatic t_catchup();
        int b;
        b = nf;
        set_cnt(64'd1060);
        repeat (8) tick();
        chk("R4 one pulse", 64'(nf - b), 64'd1);
        chk("R4 cmp ahead", cmp_q, 64'd1066);
        run(8);
        chk("R4 next count", 64'(nf - b), 64'd2);
        chk("R4 next at", flog[(b + 1) % 64], 64'd1066);
    endtask

    task automatic t_narrow_periodic();
        int b;
        wr_cfg(NAR | PER | SETV);
        wr_lo(32'h200);
        wr_lo(32'h8000_0005);
        set_cnt(64'h0000_00AB_0000_01F0);
        b = nf;
        wr_cfg(EN | NAR | PER);
        run(32);
        chk("R7 R8 count", 64'(nf - b), 64'd4);
        chk("R8 first", flog[b % 64], 64'h0000_00AB_0000_0200);
        chk("R7 last", flog[(b + 3) % 64], 64'h0000_00AB_0000_020F);
        chk("R7 cmp", cmp_q, 64'h214);
    endtask

    task automatic t_wrap();
        int b;
        wr_cfg(NAR);
        set_cnt(64'h0000_0005_FFFF_FFF8);
        wr_lo(32'd6);
        wr_hi(32'h1234);
        chk("R8 hi ignored", cmp_q, 64'd6);
        b = nf;
        wr_cfg(EN | NAR);
        run(20);
        chk("R9 count", 64'(nf - b), 64'd2);
        chk("R9 wrap", flog[b % 64], 64'h0000_0006_0000_0000);
        chk("R9 match", flog[(b + 1) % 64], 64'h0000_0006_0000_0006);
    endtask

    task automatic t_global();
        int b;
        wr_cfg(5'h00);
        set_cnt(64'd180);
        wr_lo(32'd200);
        tick(); glb_en = 1'b0;
        b = nf;
        wr_cfg(EN);
        run(30);
        chk("R10 gated", 64'(nf - b), 64'd0);
        set_cnt(64'd190);
        tick(); glb_en = 1'b1;
        run(20);
        chk("R10 global arm", 64'(nf - b), 64'd1);
        chk("R10 global at", flog[b % 64], 64'd200);
    endtask

    task automatic t_level();
        int b;
        wr_cfg(LVL);
        set_cnt(64'd50);
        wr_lo(32'd55);
        b = nf;
        wr_cfg(EN | LVL);
        run(10);
        chk("R12 level fire", 64'(nf - b), 64'd1);
        chk("R12 held", {63'd0, irq_o}, 64'd1);
        tick(); irq_ack = 1'b1;
        tick(); irq_ack = 1'b0;
        chk("R12 ack", {63'd0, irq_o}, 64'd0);
        wr_lo(32'd70);
        run(15);
        chk("R11 rearm", 64'(nf - b), 64'd2);
        chk("R11 at", flog[(b + 1) % 64], 64'd70);
        chk("R11 irq", {63'd0, irq_o}, 64'd1);
        wr_cfg(LVL);
        chk("R10 disarm irq", {63'd0, irq_o}, 64'd0);
    endtask

    initial begin
        fork
            begin
                repeat (3) tick();
                rst_n = 1'b1;
                t_reset();
                t_oneshot();
                t_periodic();
                t_catchup();
                t_narrow_periodic();
                t_wrap();
                t_global();
                t_level();
            end
            begin
                repeat (200000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule